// File: doc/BRIEF.md
# Write-Through Byte Cache with Device Bypass and DMA Snoop

This block sits between a processor's byte-wide load/store port and a memory port. It keeps a small direct-mapped store of recently read lines so that repeated loads are answered without touching memory. Every store is passed on to memory. A store to a resident line also updates the cached copy, so memory and cache never disagree.

Only addresses inside a window set by two parameters are ever kept. Anything outside that window, such as memory-mapped peripherals, goes to memory on every access and leaves the cache as it was. A snoop input reports the line address of each write made by a DMA engine, and a matching resident line is dropped. A one-cycle invalidate-all pulse empties the whole cache. After either event, the next load of the affected data fetches a fresh copy.

The processor starts an access with a one-cycle request while the block is idle and waits for a one-cycle done pulse. Memory accesses use a request/acknowledge handshake. A read always returns the whole aligned line.

Top module: `wt_dcache`

## Requirements
- R1: A load whose line is resident returns the cached byte with a one-cycle `cpu_done` pulse and makes no memory transaction.
- R2: A load in the cacheable window whose line is not resident makes exactly one memory read, returns the addressed byte, and installs the line, so that a repeat load of that line hits.
- R3: Every store makes exactly one memory write carrying the full byte address and the store data, and makes no memory read.
- R4: A store whose line is resident also updates the cached byte, so a later load returns the new value without a memory read. A store to a line that is not resident does not install it.
- R5: An address is cacheable only if CACHE_BASE <= address <= CACHE_LIMIT (defaults 0x0400 and 0x7FFF). A load outside the window always reads memory and never changes which lines are resident.
- R6: A snoop pulse whose line address matches a resident line invalidates that line. A snoop with the same index but a different tag leaves the resident line valid.
- R7: An `inv_all` pulse invalidates every line by the next cycle, so every later load misses once.
- R8: If a snoop to the same index, or an `inv_all` pulse, arrives at any point from the cycle a load miss is accepted through the cycle its memory data arrives (that cycle included), the line is not installed. The load still returns the memory data.
- R9: After reset, `cpu_busy`, `cpu_done` and `mem_req` are low and no line is resident.
- R10: `cpu_req` raised while `cpu_busy` is high is ignored: it starts no memory transaction and produces no done pulse.
- R11: The memory read data holds the aligned 4-byte line, with byte k in bits [8k+7:8k]. `mem_addr` carries the byte address and stays stable while `mem_req` waits for `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle access start, taken only while idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_busy | output | 1 | An access is in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load data, valid with `cpu_done` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 16 | Byte address to memory |
| mem_wdata | output | 8 | Write data to memory |
| mem_ack | input | 1 | Memory completes the access in this cycle |
| mem_rdata | input | 32 | Aligned line returned on a read |
| snp_valid | input | 1 | DMA write observed |
| snp_line | input | 14 | Line address (byte address without offset) of the DMA write |
| inv_all | input | 1 | Invalidate every line |

## Verification
The hardest case to reach is a snoop or invalidate-all that lands inside a pending line fill, in particular in the exact cycle the memory acknowledges. The bench pins the memory model's response delay to a known value, waits for `mem_req`, and counts cycles so that the snoop pulse coincides with the acknowledge or falls before it. A following load must then miss. Around these directed cases, random loads, stores, DMA writes and flushes run over a few indices and tags on both sides of the window edges, and a bench model predicts hits and misses.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MEM  = 2'd2,
    ST_RESP = 2'd3
  } wtc_state_e;
endpackage

// File: rtl/wtc_region.sv
module wtc_region #(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CACHE_BASE  = 16'h0400,
  parameter logic [ADDR_W-1:0] CACHE_LIMIT = 16'h7FFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              cacheable
);
  // inclusive window; everything else is treated as device space
  assign cacheable = (addr >= CACHE_BASE) && (addr <= CACHE_LIMIT);
endmodule

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  input  logic             fill_en,
  input  logic             snp_valid,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             flush
);
  logic [LINES-1:0] valid_q, valid_n;
  logic [TAG_W-1:0] tag_q [LINES];
  logic             snp_kill;

  assign look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
  assign snp_kill = snp_valid && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

  // next valid vector: invalidate-all over snoop over fill
  always_comb begin
    valid_n = valid_q;
    if (fill_en)  valid_n[look_idx] = 1'b1;
    if (snp_kill) valid_n[snp_idx]  = 1'b0;
    if (flush)    valid_n           = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_n;
  end

  // tag array, one enable per entry
  for (genvar g = 0; g < LINES; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (fill_en && (look_idx == IDX_W'(g))) tag_q[g] <= look_tag;
    end
  end

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  p_snoop_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill |=> !valid_q[$past(snp_idx)]);
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 4,
  parameter int DATA_W     = 8,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [DATA_W-1:0] rd_byte
);
  logic [LINE_W-1:0] data_q [LINES];
  logic [LINE_W-1:0] line_n;
  logic              upd;

  assign rd_byte = data_q[idx][off*DATA_W +: DATA_W];

  always_comb begin
    line_n = data_q[idx];
    upd    = fill_en || wr_en;
    if (fill_en)    line_n = fill_line;
    else if (wr_en) line_n[off*DATA_W +: DATA_W] = wr_byte;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (upd && (idx == IDX_W'(g))) data_q[g] <= line_n;
    end
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              cacheable,
  input  logic              look_hit,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic              snp_valid,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic              flush,
  output logic              fill_en,
  output logic              wr_en
);
  wtc_state_e        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              we_q, we_n;
  logic [DATA_W-1:0] wdata_q, wdata_n, rdata_q, rdata_n;
  logic              kill_q, kill_n;
  logic              seen_q, seen_n;
  logic              snp_same;
  logic [DATA_W-1:0] lane;

  assign snp_same  = snp_valid && (snp_idx == addr_q[OFF_W +: IDX_W]);
  assign lane      = mem_rdata[addr_q[OFF_W-1:0]*DATA_W +: DATA_W];
  assign cpu_busy  = (state_q != ST_IDLE);
  assign cpu_rdata = rdata_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  always_comb begin
    state_n  = state_q;
    addr_n   = addr_q;
    we_n     = we_q;
    wdata_n  = wdata_q;
    rdata_n  = rdata_q;
    kill_n   = kill_q;
    seen_n   = seen_q;
    fill_en  = 1'b0;
    wr_en    = 1'b0;
    mem_req  = 1'b0;
    cpu_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          addr_n  = cpu_addr;
          we_n    = cpu_we;
          wdata_n = cpu_wdata;
          seen_n  = 1'b0;
          kill_n  = flush || (snp_valid && (snp_idx == cpu_addr[OFF_W +: IDX_W]));
          state_n = ST_LOOK;
        end
      end
      ST_LOOK: begin
        kill_n = kill_q || flush || snp_same;
        if (!we_q && cacheable && look_hit) begin
          rdata_n = rd_byte;
          state_n = ST_RESP;
        end else begin
          state_n = ST_MEM;
        end
      end
      ST_MEM: begin
        mem_req = 1'b1;
        kill_n  = kill_q || flush || snp_same;
        if (mem_ack) begin
          seen_n  = 1'b1;
          rdata_n = we_q ? '0 : lane;
          fill_en = !we_q && cacheable && !(kill_q || flush || snp_same);
          wr_en   = we_q && cacheable && look_hit;
          state_n = ST_RESP;
        end
      end
      ST_RESP: begin
        cpu_done = 1'b1;
        state_n  = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      kill_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      we_q    <= we_n;
      wdata_q <= wdata_n;
      rdata_q <= rdata_n;
      kill_q  <= kill_n;
      seen_q  <= seen_n;
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  p_store_reached_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && we_q) |-> seen_q);

  p_addr_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_busy) |=> $stable(addr_q));
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter int                LINES       = 16,
  parameter int                LINE_BYTES  = 4,
  parameter logic [ADDR_W-1:0] CACHE_BASE  = 16'h0400,
  parameter logic [ADDR_W-1:0] CACHE_LIMIT = 16'h7FFF,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W = LINE_BYTES * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_busy,
  output logic                    cpu_done,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [LINE_W-1:0]       mem_rdata,
  input  logic                    snp_valid,
  input  logic [ADDR_W-OFF_W-1:0] snp_line,
  input  logic                    inv_all
);
  logic              rst_meta_q, rst_sync_q;
  logic              cacheable, look_hit, fill_en, wr_en;
  logic [DATA_W-1:0] rd_byte;
  logic [IDX_W-1:0]  snp_idx;
  logic [TAG_W-1:0]  snp_tag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign snp_idx = snp_line[IDX_W-1:0];
  assign snp_tag = snp_line[ADDR_W-OFF_W-1:IDX_W];

  wtc_region #(.ADDR_W(ADDR_W), .CACHE_BASE(CACHE_BASE), .CACHE_LIMIT(CACHE_LIMIT)) u_region (
    .addr(mem_addr), .cacheable(cacheable)
  );

  wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_sync_q),
    .look_idx(mem_addr[OFF_W +: IDX_W]), .look_tag(mem_addr[ADDR_W-1 -: TAG_W]),
    .look_hit(look_hit), .fill_en(fill_en),
    .snp_valid(snp_valid), .snp_idx(snp_idx), .snp_tag(snp_tag), .flush(inv_all)
  );

  wtc_data_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) u_data (
    .clk(clk), .idx(mem_addr[OFF_W +: IDX_W]), .off(mem_addr[OFF_W-1:0]),
    .fill_en(fill_en), .fill_line(mem_rdata),
    .wr_en(wr_en), .wr_byte(mem_wdata), .rd_byte(rd_byte)
  );

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_q),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cacheable(cacheable), .look_hit(look_hit), .rd_byte(rd_byte),
    .snp_valid(snp_valid), .snp_idx(snp_idx), .flush(inv_all),
    .fill_en(fill_en), .wr_en(wr_en)
  );

  p_fill_on_read_ack_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    fill_en |-> (mem_req && mem_ack && !mem_we));

  p_device_bypass_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mem_req && !cacheable) |-> (!fill_en && !wr_en));
endmodule

// File: tb/test_wt_dcache.sv
module test_wt_dcache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_busy, cpu_done;
  logic [7:0]  cpu_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        snp_valid;
  logic [13:0] snp_line;
  logic        inv_all;

  int errs = 0, nchk = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int fix_dly = -1, cur_dly = 1, rcnt = 0;
  bit exp_kill = 0;
  logic [7:0] mem_a [int];
  bit         bm_v [16];
  logic [9:0] bm_t [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_dcache i_wt_dcache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .snp_valid(snp_valid), .snp_line(snp_line),
    .inv_all(inv_all)
  );

  function automatic logic [7:0] mem_get(input logic [15:0] a);
    if (mem_a.exists(int'(a))) return mem_a[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic bit is_cach(input logic [15:0] a);
    return (a >= 16'h0400) && (a <= 16'h7FFF);
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model, line-wide reads (R11)
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (rcnt == ((fix_dly >= 0) ? fix_dly : cur_dly)) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem_a[int'(mem_addr)] = mem_wdata;
          wr_cnt++;
        end else begin
          for (int k = 0; k < 4; k++)
            mem_rdata[k*8 +: 8] = mem_get({mem_addr[15:2], 2'(k)});
          rd_cnt++;
        end
        rcnt = 0;
        cur_dly = $urandom_range(0, 2);
      end else rcnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      nchk++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                        input string tag, input bit poke);
    int rd0 = rd_cnt, wr0 = wr_cnt, wr1;
    int idx = int'(a[5:2]);
    logic [7:0] exp_d = mem_get(a);
    bit hit = is_cach(a) && bm_v[idx] && (bm_t[idx] == a[15:6]);
    bit seen = 0, extra = 0;
    logic [7:0] got = '0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    if (poke) begin
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a ^ 16'h0100; cpu_wdata = ~wd;
      @(negedge clk);
      cpu_req = 1'b0;
    end
    for (int w = 0; w < 60 && !seen; w++) begin
      if (cpu_done) begin seen = 1; got = cpu_rdata; end
      else @(negedge clk);
    end
    check(seen, tag, "done seen", int'(seen), 1);
    if (!we) begin
      check(got == exp_d, tag, "load data", int'(got), int'(exp_d));
      check(rd_cnt - rd0 == (hit ? 0 : 1), tag, "memory reads", rd_cnt - rd0, hit ? 0 : 1);
      check(wr_cnt == wr0, tag, "memory writes on load", wr_cnt - wr0, 0);
      if (is_cach(a)) begin
        if (exp_kill) bm_v[idx] = 0;
        else begin bm_v[idx] = 1; bm_t[idx] = a[15:6]; end
      end
    end else begin
      check(wr_cnt - wr0 == 1, tag, "memory writes", wr_cnt - wr0, 1);
      check(rd_cnt == rd0, tag, "memory reads on store", rd_cnt - rd0, 0);
      check(mem_get(a) == wd, tag, "memory byte", int'(mem_get(a)), int'(wd));
    end
    if (poke) begin
      wr1 = wr_cnt;
      for (int w = 0; w < 4; w++) begin
        @(negedge clk);
        if (cpu_done) extra = 1;
      end
      check(!extra && wr_cnt == wr1 && rd_cnt - rd0 == (hit ? 0 : 1), "R10",
            "ignored request", int'(extra), 0);
    end
  endtask

  task automatic dma_write(input logic [15:0] a, input logic [7:0] v);
    int idx = int'(a[5:2]);
    mem_a[int'(a)] = v;
    @(negedge clk); snp_valid = 1'b1; snp_line = a[15:2];
    @(negedge clk); snp_valid = 1'b0;
    if (bm_v[idx] && bm_t[idx] == a[15:6]) bm_v[idx] = 0;
  endtask

  task automatic flush_all();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    for (int i = 0; i < 16; i++) bm_v[i] = 0;
  endtask

  function automatic logic [15:0] rand_addr();
    logic [9:0] tg;
    case ($urandom_range(0, 4))
      0: tg = 10'h010;
      1: tg = 10'h011;
      2: tg = 10'h1FF;
      3: tg = 10'h200;
      default: tg = 10'h000;
    endcase
    return {tg, 4'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    mem_ack = 0; mem_rdata = '0; snp_valid = 0; snp_line = '0; inv_all = 0;
    for (int i = 0; i < 16; i++) begin bm_v[i] = 0; bm_t[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(!cpu_busy, "R9", "busy after reset", int'(cpu_busy), 0);
    check(!cpu_done, "R9", "done after reset", int'(cpu_done), 0);
    check(!mem_req, "R9", "mem_req after reset", int'(mem_req), 0);
    access(0, 16'h0404, 8'h00, "R9", 0);      // first load must miss
    access(0, 16'h0405, 8'h00, "R1", 0);      // same line: hit
    access(0, 16'h0418, 8'h00, "R2", 0);
    access(0, 16'h041B, 8'h00, "R2", 0);
    // R4 store hit then load hit; store miss stays unallocated
    access(1, 16'h0406, 8'hA5, "R4", 0);
    access(0, 16'h0406, 8'h00, "R4", 0);
    access(1, 16'h0840, 8'h3C, "R3", 0);
    access(0, 16'h0840, 8'h00, "R4", 0);
    // R5 window edges and bypass leaving state intact
    access(0, 16'h03FF, 8'h00, "R5", 0);
    access(0, 16'h03FF, 8'h00, "R5", 0);
    access(0, 16'h8000, 8'h00, "R5", 0);
    access(0, 16'h8000, 8'h00, "R5", 0);
    access(0, 16'h0400, 8'h00, "R5", 0);
    access(0, 16'h0400, 8'h00, "R5", 0);
    access(0, 16'h7FFF, 8'h00, "R5", 0);
    access(0, 16'h7FFF, 8'h00, "R5", 0);
    access(0, 16'h8004, 8'h00, "R5", 0);
    access(0, 16'h0404, 8'h00, "R5", 0);
    access(1, 16'h8005, 8'h77, "R5", 0);
    // R6 snoops
    dma_write(16'h0405, 8'hE1);
    access(0, 16'h0405, 8'h00, "R6", 0);
    dma_write(16'h0C04, 8'h19);
    access(0, 16'h0404, 8'h00, "R6", 0);
    // R7 invalidate-all
    access(0, 16'h0418, 8'h00, "R7", 0);
    flush_all();
    access(0, 16'h0404, 8'h00, "R7", 0);
    access(0, 16'h0418, 8'h00, "R7", 0);
    // R8 snoop during pending fill
    flush_all();
    fix_dly = 3; exp_kill = 1;
    fork
      access(0, 16'h0410, 8'h00, "R8", 0);
      begin
        @(negedge clk);
        while (!mem_req) @(negedge clk);
        snp_valid = 1'b1; snp_line = 14'h0304;
        @(negedge clk); snp_valid = 1'b0;
      end
    join
    exp_kill = 0;
    access(0, 16'h0410, 8'h00, "R8", 0);
    // R8 snoop in the acknowledge cycle
    flush_all();
    exp_kill = 1;
    fork
      access(0, 16'h0424, 8'h00, "R8", 0);
      begin
        @(negedge clk);
        while (!mem_req) @(negedge clk);
        repeat (3) @(negedge clk);
        snp_valid = 1'b1; snp_line = 14'h0309;
        @(negedge clk); snp_valid = 1'b0;
      end
    join
    exp_kill = 0;
    access(0, 16'h0424, 8'h00, "R8", 0);
    // R8 invalidate-all during pending fill
    exp_kill = 1;
    fork
      access(0, 16'h0438, 8'h00, "R8", 0);
      begin
        @(negedge clk);
        while (!mem_req) @(negedge clk);
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
      end
    join
    exp_kill = 0;
    for (int i = 0; i < 16; i++) bm_v[i] = 0;
    access(0, 16'h0438, 8'h00, "R8", 0);
    fix_dly = -1;
    // R10 request while busy
    access(0, 16'h0450, 8'h11, "R10", 1);
    // random mix, memory read stable address and lanes checked via data (R11)
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 19);
      logic [15:0] a = rand_addr();
      if (r < 10)      access(0, a, 8'h00, "R11", 0);
      else if (r < 16) access(1, a, 8'($urandom_range(0, 255)), "R3", 0);
      else if (r < 19) dma_write(a, 8'($urandom_range(0, 255)));
      else             flush_all();
    end
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule